// File: doc/BRIEF.md
# Two-Base Delta Cache Line Codec

The block packs a 64-byte cache line into a small image. The line is split into eight 64-bit elements. Each element is stored as a one-byte signed offset from one of two bases. The first base is always zero, so it never appears in the image. The second base is the value of the lowest-indexed element that cannot be written as a one-byte offset from zero. Each element also carries a selector bit that names its base. All eight elements are examined side by side, and the compressed result is registered one cycle after the line is presented.

If any element fits neither base, the line is declared incompressible. It is then passed through untouched, with the success flag low.

A separate combinational path rebuilds a line from a packed image. It takes the base, the selector mask and the eight offsets as inputs. The host feeds a stored image back through this path to recover the original line.

Top module: `bdi_line_codec`

## Requirements
- R1: Element i occupies line bits [64i+63:64i]. An element whose value, read as signed, lies in -128..127 is encoded against zero: selector 0, offset = its low byte. This holds even when it would also fit the explicit base.
- R2: The explicit base is the lowest-indexed element that fails R1. It is stored in image bits [63:0]. When every element passes R1, those bits are zero and the selector mask is zero.
- R3: An element that fails R1 gets selector 1 and offset = (element - base) mod 2^64. This offset must lie in -128..127 as a signed value; the base element itself gets offset 0.
- R4: On success, the image holds the base in bits [63:0], selector i in bit 64+i, and offset i in bits [72+8i+7:72+8i]. Bits 511..136 are zero, the size output reads 17 (bytes) and the success flag is 1.
- R5: If any element fits neither base, the success flag is 0, the size output reads 64, and the image equals the input line bit for bit.
- R6: The output valid pulses high exactly one cycle after each input valid cycle. The image, size and flag change only on accepted lines and hold otherwise.
- R7: While reset is asserted (active low), output valid, success flag, size and image are all zero.
- R8: The rebuild path outputs, for every i, element i = sign-extended offset i plus (selector i ? base : 0), modulo 2^64. There is no clock delay.
- R9: Feeding a successful image's base, mask and offsets back into the rebuild path reproduces the original line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Line present this cycle |
| in_line | input | 512 | Uncompressed line, element i at bits 64i+63:64i |
| pk_valid | output | 1 | Result valid (one cycle after in_valid) |
| pk_fit | output | 1 | Line compressed successfully |
| pk_bytes | output | 7 | Size of the result in bytes (17 or 64) |
| pk_image | output | 512 | Packed image, or the raw line when not fitted |
| up_base | input | 64 | Explicit base of an image to rebuild |
| up_sel | input | 8 | Selector mask, bit i names the base of element i |
| up_delta | input | 64 | Eight offsets, offset i at bits 8i+7:8i |
| up_line | output | 512 | Rebuilt line |

## Verification
The bench targets offsets at exactly +127 and -128, and one step beyond. A range check off by one would either reject a valid line or accept one that rebuilds wrong. It places the first non-small element at index 0 and at index 7, and uses an element equal to +128 against zero. A design that scanned from the wrong end, or tested the range unsigned, would pick the wrong base. Base arithmetic that wraps past 2^63 and negative bases check that offsets are taken modulo 2^64. Small elements mixed with large ones check that a design preferring the explicit base does not flip selector bits. Failed lines must come out as the raw line with size 64. The output must hold between inputs.

// File: rtl/bdi_pkg.sv
package bdi_pkg;
  localparam int ElemW  = 64;
  localparam int NElem  = 8;
  localparam int DeltaW = 8;

  typedef enum logic {
    SEL_ZERO = 1'b0,
    SEL_BASE = 1'b1
  } base_sel_e;
endpackage

// File: rtl/bdi_base_pick.sv
module bdi_base_pick #(
  parameter int EW = 64,
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic [EW*N-1:0] line,
  output logic [N-1:0]    zero_fit,
  output logic [EW-1:0]   base,
  output logic            found
);
  // value fits a DW-bit signed field when all bits above the field sign agree
  function automatic logic fits_narrow(input logic [EW-1:0] v);
    return (&v[EW-1:DW-1]) | ~(|v[EW-1:DW-1]);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_zf
    assign zero_fit[g] = fits_narrow(line[g*EW +: EW]);
  end

  // lowest index that misses zero wins: scan downward, last hit sticks
  always_comb begin
    found = 1'b0;
    base  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!zero_fit[i]) begin
        found = 1'b1;
        base  = line[i*EW +: EW];
      end
    end
  end
endmodule

// File: rtl/bdi_lane_enc.sv
module bdi_lane_enc
  import bdi_pkg::*;
#(
  parameter int EW = 64,
  parameter int DW = 8
) (
  input  logic [EW-1:0] elem,
  input  logic [EW-1:0] base,
  input  logic          zero_fit,
  output base_sel_e     sel,
  output logic [DW-1:0] delta,
  output logic          lane_ok
);
  function automatic logic fits_narrow(input logic [EW-1:0] v);
    return (&v[EW-1:DW-1]) | ~(|v[EW-1:DW-1]);
  endfunction

  function automatic logic [EW-1:0] offset_of(input logic [EW-1:0] v, input logic [EW-1:0] b);
    return v - b;
  endfunction

  logic [EW-1:0] diff;
  logic          base_fit;

  assign diff     = offset_of(elem, base);
  assign base_fit = fits_narrow(diff);
  assign sel      = zero_fit ? SEL_ZERO : SEL_BASE;
  assign delta    = zero_fit ? elem[DW-1:0] : diff[DW-1:0];
  assign lane_ok  = zero_fit | base_fit;
endmodule

// File: rtl/bdi_lane_dec.sv
module bdi_lane_dec #(
  parameter int EW = 64,
  parameter int DW = 8
) (
  input  logic [DW-1:0] delta,
  input  logic          sel,
  input  logic [EW-1:0] base,
  output logic [EW-1:0] elem
);
  function automatic logic [EW-1:0] widen(input logic [DW-1:0] d);
    return {{(EW - DW){d[DW-1]}}, d};
  endfunction

  assign elem = widen(delta) + (sel ? base : '0);
endmodule

// File: rtl/bdi_line_codec.sv
module bdi_line_codec
  import bdi_pkg::*;
#(
  parameter int EW = bdi_pkg::ElemW,
  parameter int N  = bdi_pkg::NElem,
  parameter int DW = bdi_pkg::DeltaW,
  localparam int LineW  = EW * N,
  localparam int PackW  = EW + N + N * DW,
  localparam int SizeW  = $clog2(LineW / 8 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LineW-1:0] in_line,
  output logic             pk_valid,
  output logic             pk_fit,
  output logic [SizeW-1:0] pk_bytes,
  output logic [LineW-1:0] pk_image,
  input  logic [EW-1:0]    up_base,
  input  logic [N-1:0]     up_sel,
  input  logic [N*DW-1:0]  up_delta,
  output logic [LineW-1:0] up_line
);
  localparam logic [SizeW-1:0] PackBytes = SizeW'(PackW / 8);
  localparam logic [SizeW-1:0] LineBytes = SizeW'(LineW / 8);

  // named internal events, observed by the bound checker
  logic [N-1:0]    zero_fit;
  logic [N-1:0]    lane_ok;
  logic [N-1:0]    sel_mask;
  logic [N*DW-1:0] deltas;
  logic [EW-1:0]   base;
  logic            base_found;
  logic            line_ok;
  logic [LineW-1:0] image_next;

  bdi_base_pick #(.EW(EW), .N(N), .DW(DW)) pick_i (
    .line     (in_line),
    .zero_fit (zero_fit),
    .base     (base),
    .found    (base_found)
  );

  for (genvar g = 0; g < N; g++) begin : g_enc
    base_sel_e s;
    bdi_lane_enc #(.EW(EW), .DW(DW)) enc_i (
      .elem     (in_line[g*EW +: EW]),
      .base     (base),
      .zero_fit (zero_fit[g]),
      .sel      (s),
      .delta    (deltas[g*DW +: DW]),
      .lane_ok  (lane_ok[g])
    );
    assign sel_mask[g] = (s == SEL_BASE);
  end

  assign line_ok = &lane_ok;

  always_comb begin
    image_next = '0;
    if (line_ok) image_next[PackW-1:0] = {deltas, sel_mask, base};
    else         image_next = in_line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_valid <= 1'b0;
      pk_fit   <= 1'b0;
      pk_bytes <= '0;
      pk_image <= '0;
    end else begin
      pk_valid <= in_valid;
      if (in_valid) begin
        pk_fit   <= line_ok;
        pk_bytes <= line_ok ? PackBytes : LineBytes;
        pk_image <= image_next;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dec
    bdi_lane_dec #(.EW(EW), .DW(DW)) dec_i (
      .delta (up_delta[g*DW +: DW]),
      .sel   (up_sel[g]),
      .base  (up_base),
      .elem  (up_line[g*EW +: EW])
    );
  end
endmodule

// File: rtl/bdi_line_codec_chk.sv
module bdi_line_codec_chk #(
  parameter int EW = 64,
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LineW = EW * N,
  localparam int PackW = EW + N + N * DW,
  localparam int SizeW = $clog2(LineW / 8 + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [LineW-1:0] in_line,
  input logic             pk_valid,
  input logic             pk_fit,
  input logic [SizeW-1:0] pk_bytes,
  input logic [LineW-1:0] pk_image,
  input logic [EW-1:0]    up_base,
  input logic [N-1:0]     up_sel,
  input logic [N*DW-1:0]  up_delta,
  input logic [LineW-1:0] up_line,
  input logic [N-1:0]     zero_fit,
  input logic             base_found
);
  // R6
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> pk_valid);
  // R6
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !pk_valid);
  // R6
  image_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pk_image) && $stable(pk_fit) && $stable(pk_bytes)));
  // R5
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_valid && !pk_fit) |-> (pk_bytes == SizeW'(LineW / 8) && pk_image == $past(in_line)));
  // R4
  packed_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_valid && pk_fit) |-> (pk_bytes == SizeW'(PackW / 8) && pk_image[LineW-1:PackW] == '0));
  // R2
  no_base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !base_found) |=> (pk_fit && pk_image[EW-1:0] == '0));
  // R1
  all_small_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&zero_fit)) |=> (pk_fit && pk_image[EW +: N] == '0));
  // R9
  roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_valid && pk_fit && up_base == pk_image[EW-1:0] && up_sel == pk_image[EW +: N]
     && up_delta == pk_image[EW+N +: N*DW]) |-> (up_line == $past(in_line)));
endmodule

bind bdi_line_codec bdi_line_codec_chk #(.EW(EW), .N(N), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_line    (in_line),
  .pk_valid   (pk_valid),
  .pk_fit     (pk_fit),
  .pk_bytes   (pk_bytes),
  .pk_image   (pk_image),
  .up_base    (up_base),
  .up_sel     (up_sel),
  .up_delta   (up_delta),
  .up_line    (up_line),
  .zero_fit   (zero_fit),
  .base_found (base_found)
);

// File: tb/bdi_line_codec_tb.sv
module bdi_line_codec_tb_top;
  localparam int ClkPeriod = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] in_line = '0;
  logic         pk_valid, pk_fit;
  logic [6:0]   pk_bytes;
  logic [511:0] pk_image;
  logic [63:0]  up_base = '0;
  logic [7:0]   up_sel = '0;
  logic [63:0]  up_delta = '0;
  logic [511:0] up_line;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  bdi_line_codec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line),
    .pk_valid(pk_valid), .pk_fit(pk_fit), .pk_bytes(pk_bytes), .pk_image(pk_image),
    .up_base(up_base), .up_sel(up_sel), .up_delta(up_delta), .up_line(up_line)
  );

  function automatic logic [511:0] mk(input logic [63:0] e0, e1, e2, e3, e4, e5, e6, e7);
    return {e7, e6, e5, e4, e3, e2, e1, e0};
  endfunction

  typedef struct packed {
    logic [511:0] line;
    logic         ok;
  } vec_t;

  localparam int NVec = 9;
  localparam vec_t VECS [NVec] = '{
    // all small, edges 127 and -128 against zero (R1)
    '{line: mk(64'd5, -64'sd3, 64'd127, -64'sd128, 64'd0, 64'd1, 64'd2, 64'd100), ok: 1'b1},
    // pointer stride, base at index 0 (R3)
    '{line: mk(64'h1000_0000_0000_0000, 64'h1000_0000_0000_0008, 64'h1000_0000_0000_0010,
               64'h1000_0000_0000_0018, 64'h1000_0000_0000_0020, 64'h1000_0000_0000_0028,
               64'h1000_0000_0000_0030, 64'h1000_0000_0000_0038), ok: 1'b1},
    // mixed, offsets -128 and +127 against base (R1, R3)
    '{line: mk(64'd0, 64'h4000_0000, 64'h4000_0010, -64'sd5, 64'h3FFF_FF80,
               64'h4000_007F, 64'd7, 64'h4000_0000), ok: 1'b1},
    // one element at base+128 (R5)
    '{line: mk(64'h40_0000_0000, 64'd1, 64'd2, 64'd3, 64'd4, 64'h40_0000_0080, 64'd6, 64'd7), ok: 1'b0},
    // three unrelated large values (R5)
    '{line: mk(64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 64'h3333_3333_3333_3333,
               64'd0, 64'd0, 64'd0, 64'd0, 64'd0), ok: 1'b0},
    // only index 7 large (R2)
    '{line: mk(64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6, 64'd7, 64'hDEAD_BEEF_0000_0000), ok: 1'b1},
    // offset across the signed boundary (R3)
    '{line: mk(64'h7FFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0005, 64'd0, 64'd0,
               64'd0, 64'd0, 64'd0, 64'd0), ok: 1'b1},
    // negative base (R2, R3)
    '{line: mk(-64'sd1000, -64'sd1100, -64'sd128, -64'sd900, 64'd0, 64'd0, 64'd0, 64'd0), ok: 1'b1},
    // +128 is not small, becomes the base (R1, R2)
    '{line: mk(64'd3, 64'd128, 64'd200, 64'd9, 64'd0, 64'd0, 64'd0, 64'd0), ok: 1'b1}
  };

  // independent model written from the requirements
  function automatic void model(input logic [511:0] ln, output logic ok,
                                output logic [511:0] img, output logic [6:0] sz);
    longint signed e [8];
    longint signed b, d;
    bit have_b;
    logic [7:0] mask;
    logic [63:0] dl;
    have_b = 0; b = 0; ok = 1; mask = '0; dl = '0;
    for (int i = 0; i < 8; i++) e[i] = ln[64*i +: 64];
    for (int i = 0; i < 8; i++)
      if (!have_b && (e[i] < -128 || e[i] > 127)) begin have_b = 1; b = e[i]; end
    for (int i = 0; i < 8; i++) begin
      if (e[i] >= -128 && e[i] <= 127) begin
        dl[8*i +: 8] = e[i][7:0];
      end else begin
        d = e[i] - b;
        mask[i] = 1'b1;
        dl[8*i +: 8] = d[7:0];
        if (d < -128 || d > 127) ok = 0;
      end
    end
    if (ok) begin img = '0; img[135:0] = {dl, mask, 64'(b)}; sz = 7'd17; end
    else    begin img = ln; sz = 7'd64; end
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [511:0] ln);
    @(negedge clk);
    in_valid = 1'b1; in_line = ln;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic m_ok;
    logic [511:0] m_img;
    logic [6:0] m_sz;
    logic [511:0] held;
    logic [511:0] exp_line;

    // R7 reset state
    repeat (3) @(negedge clk);
    check("R7 valid", 512'(pk_valid), 512'(0));
    check("R7 fit", 512'(pk_fit), 512'(0));
    check("R7 size", 512'(pk_bytes), 512'(0));
    check("R7 image", pk_image, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NVec; v++) begin
      model(VECS[v].line, m_ok, m_img, m_sz);
      check("R5 model vs table", 512'(m_ok), 512'(VECS[v].ok));
      send(VECS[v].line);
      check("R6 valid", 512'(pk_valid), 512'(1));
      check(m_ok ? "R4 fit" : "R5 fit", 512'(pk_fit), 512'(m_ok));
      check(m_ok ? "R4 size" : "R5 size", 512'(pk_bytes), 512'(m_sz));
      check(m_ok ? "R1 R2 R3 R4 image" : "R5 image", pk_image, m_img);
      if (pk_fit) begin
        up_base = pk_image[63:0]; up_sel = pk_image[71:64]; up_delta = pk_image[135:72];
        #1;
        check("R9 roundtrip", up_line, VECS[v].line);
      end
      held = pk_image;
      @(negedge clk);
      check("R6 pulse", 512'(pk_valid), 512'(0));
      check("R6 hold", pk_image, held);
    end

    // R8 rebuild from arbitrary fields
    up_base = 64'h0123_4567_89AB_CDEF; up_sel = 8'hA5; up_delta = 64'h80_7F_01_FF_00_10_F0_55;
    #1;
    for (int i = 0; i < 8; i++) begin
      longint signed d;
      d = longint'($signed(up_delta[8*i +: 8]));
      exp_line[64*i +: 64] = 64'(d) + (up_sel[i] ? up_base : 64'd0);
    end
    check("R8 rebuild", up_line, exp_line);

    // R7 reset again after activity
    send(VECS[1].line);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 image after reset", pk_image, '0);
    check("R7 fit after reset", 512'(pk_fit), 512'(0));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule